// File: doc/BRIEF.md
# Split Serial Delay Line

The block is a bit-serial delay line made of two independent halves, A and B. Each half always contains a fixed run of 20 storage cells. A per-half extension of 0 to 80 further cells is added to that run, so one half delays its input by between 20 and 100 rising clock edges. The two halves may be set to different lengths.

A mode input chooses how the halves are joined:

- **Separate:** the halves work as two delay lines. Half B can take its own serial input, or it can share half A's input.
- **Chained:** A's output drives B's input, which gives one line of 40 to 200 cycles.
- **Chained with tap:** the line is chained as above, and the bit leaving half A is also presented on a tap output.

Lengths, mode and the sharing option are captured while reset is asserted. They then stay fixed until the next reset. A clock enable freezes every cell when it is low.

Top module: `split_delay_line`

## Requirements
- R1: While reset is high, every storage cell clears. From the first edge after reset until enough enabled edges have passed, out_a, out_b and tap_out read 0.
- R2: In separate mode (mode 0, or mode 3, which behaves the same), out_a equals din_a as it was sampled exactly 20+ext_a enabled edges earlier.
- R3: In separate mode with share_in low, out_b equals din_b delayed by 20+ext_b enabled edges. The two halves may have unequal lengths.
- R4: In separate mode with share_in high, half B takes din_a instead, and out_b equals din_a delayed by 20+ext_b enabled edges. din_b has no effect.
- R5: In chained mode (mode 1), out_b equals din_a delayed by (20+ext_a)+(20+ext_b) enabled edges. out_a and tap_out stay 0.
- R6: In chained-with-tap mode (mode 2), out_b behaves as in R5. tap_out equals din_a delayed by 20+ext_a enabled edges, and out_a stays 0.
- R7: An extension value above 80 is treated as 80. config_error reads 1 after reset when either captured extension exceeded 80, and 0 otherwise. It holds its value until the next reset.
- R8: An edge with ce low changes no cell and no output. Delays are counted in edges where ce was high.
- R9: Changes to mode, share_in, ext_a or ext_b while reset is low have no effect on any output.
- R10: Mode value 3 gives exactly the separate-mode behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| ce | input | 1 | Clock enable; low freezes all cells |
| mode | input | 2 | 0 separate, 1 chained, 2 chained with tap, 3 separate |
| share_in | input | 1 | Separate mode: half B takes din_a |
| ext_a | input | 7 | Extension cells for half A (saturates at 80) |
| ext_b | input | 7 | Extension cells for half B (saturates at 80) |
| din_a | input | 1 | Serial data into half A |
| din_b | input | 1 | Serial data into half B (separate, unshared) |
| out_a | output | 1 | Half A output in separate mode, else 0 |
| out_b | output | 1 | Half B output; end of the line in chained modes |
| tap_out | output | 1 | Half A output in chained-with-tap mode, else 0 |
| config_error | output | 1 | An extension above 80 was captured |

## Verification
The assertions rest on one assumption: configuration reaches the block only through a reset phase of at least one edge. The bench respects this by driving every configuration before it raises reset. The bench also changes the configuration inputs after release, and the assertions must still hold then. Clock enable is assumed to be a plain level with no relation to the data. The stimulus drops it pseudo-randomly, so that the hold property is exercised in every mode.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    SDL_SEPARATE  = 2'd0,
    SDL_CHAINED   = 2'd1,
    SDL_TAPPED    = 2'd2,
    SDL_SEPARATE2 = 2'd3
  } sdl_mode_e;

  function automatic logic sdl_is_chained(input sdl_mode_e m);
    return (m == SDL_CHAINED) || (m == SDL_TAPPED);
  endfunction
endpackage

// File: rtl/sdl_cfg.sv
module sdl_cfg #(
  parameter int EXT_MAX = 80,
  parameter int EXT_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               share_in,
  input  logic [EXT_W-1:0]   ext_a,
  input  logic [EXT_W-1:0]   ext_b,
  output sdl_pkg::sdl_mode_e mode_q,
  output logic               share_q,
  output logic [EXT_W-1:0]   ext_a_q,
  output logic [EXT_W-1:0]   ext_b_q,
  output logic               err_q
);
  localparam logic [EXT_W-1:0] LIMIT = EXT_W'(EXT_MAX);

  logic over_a, over_b;
  assign over_a = ext_a > LIMIT;
  assign over_b = ext_b > LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= sdl_pkg::sdl_mode_e'(mode);
      share_q <= share_in;
      ext_a_q <= over_a ? LIMIT : ext_a;
      ext_b_q <= over_b ? LIMIT : ext_b;
      err_q   <= over_a | over_b;
    end
  end
endmodule

// File: rtl/sdl_half.sv
module sdl_half #(
  parameter int FIXED_LEN = 20,
  parameter int EXT_MAX   = 80,
  parameter int EXT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             din,
  input  logic [EXT_W-1:0] ext,
  output logic             dout
);
  localparam int MAX_LEN = FIXED_LEN + EXT_MAX;
  localparam int CHAIN   = MAX_LEN - 1;
  localparam int IDX_W   = $clog2(MAX_LEN);

  logic [CHAIN-1:0] cells;
  logic [IDX_W-1:0] pick;

  // The output register is the last stage, so the chain feeding it is one
  // cell shorter than the programmed length.
  assign pick = IDX_W'(FIXED_LEN - 2) + IDX_W'(ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      cells <= '0;
      dout  <= 1'b0;
    end else if (ce) begin
      cells <= {cells[CHAIN-2:0], din};
      dout  <= cells[pick];
    end
  end
endmodule

// File: rtl/split_delay_line.sv
module split_delay_line #(
  parameter int FIXED_LEN = 20,
  parameter int EXT_MAX   = 80,
  parameter int EXT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [1:0]       mode,
  input  logic             share_in,
  input  logic [EXT_W-1:0] ext_a,
  input  logic [EXT_W-1:0] ext_b,
  input  logic             din_a,
  input  logic             din_b,
  output logic             out_a,
  output logic             out_b,
  output logic             tap_out,
  output logic             config_error
);
  import sdl_pkg::*;

  sdl_mode_e        mode_eff;
  logic             share_eff;
  logic [EXT_W-1:0] ext_a_eff, ext_b_eff;
  logic             a_q, b_q, b_in, chained;

  sdl_cfg #(.EXT_MAX(EXT_MAX), .EXT_W(EXT_W)) u_cfg (
    .clk(clk), .rst(rst), .mode(mode), .share_in(share_in),
    .ext_a(ext_a), .ext_b(ext_b), .mode_q(mode_eff), .share_q(share_eff),
    .ext_a_q(ext_a_eff), .ext_b_q(ext_b_eff), .err_q(config_error)
  );

  assign chained = sdl_is_chained(mode_eff);
  assign b_in    = chained ? a_q : (share_eff ? din_a : din_b);

  sdl_half #(.FIXED_LEN(FIXED_LEN), .EXT_MAX(EXT_MAX), .EXT_W(EXT_W)) u_half_a (
    .clk(clk), .rst(rst), .ce(ce), .din(din_a), .ext(ext_a_eff), .dout(a_q)
  );

  sdl_half #(.FIXED_LEN(FIXED_LEN), .EXT_MAX(EXT_MAX), .EXT_W(EXT_W)) u_half_b (
    .clk(clk), .rst(rst), .ce(ce), .din(b_in), .ext(ext_b_eff), .dout(b_q)
  );

  assign out_a   = chained ? 1'b0 : a_q;
  assign tap_out = (mode_eff == SDL_TAPPED) ? a_q : 1'b0;
  assign out_b   = b_q;
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
  parameter int EXT_MAX = 80,
  parameter int EXT_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             out_a,
  input logic             out_b,
  input logic             tap_out,
  input logic             config_error,
  input logic [1:0]       mode_eff,
  input logic [EXT_W-1:0] ext_a_eff,
  input logic [EXT_W-1:0] ext_b_eff
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_a == 1'b0) && (out_b == 1'b0) && (tap_out == 1'b0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(out_a) && $stable(out_b) && $stable(tap_out));

  // R7
  err_steady_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(config_error));

  // R7
  ext_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_a_eff <= EXT_W'(EXT_MAX)) && (ext_b_eff <= EXT_W'(EXT_MAX)));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode_eff) && $stable(ext_a_eff) && $stable(ext_b_eff));

  // R5
  chained_a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_eff == 2'd1) |-> (out_a == 1'b0) && (tap_out == 1'b0));
endmodule

bind split_delay_line sdl_chk #(.EXT_MAX(EXT_MAX), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .out_a(out_a), .out_b(out_b),
  .tap_out(tap_out), .config_error(config_error), .mode_eff(mode_eff),
  .ext_a_eff(ext_a_eff), .ext_b_eff(ext_b_eff)
);

// File: tb/split_delay_line_tb.sv
`timescale 1ns/100ps
module split_delay_line_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [1:0] mode = 2'd0;
  logic share_in = 1'b0;
  logic [6:0] ext_a = 7'd0, ext_b = 7'd0;
  logic din_a = 1'b0, din_b = 1'b0;
  logic out_a, out_b, tap_out, config_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ha [0:1023];
  int hb [0:1023];

  always #2.5 clk = ~clk;

  split_delay_line u_dut (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode), .share_in(share_in),
    .ext_a(ext_a), .ext_b(ext_b), .din_a(din_a), .din_b(din_b),
    .out_a(out_a), .out_b(out_b), .tap_out(tap_out), .config_error(config_error)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int delayed(input bit use_b, input int n, input int len);
    if (n < len) return 0;
    return use_b ? hb[n-len] : ha[n-len];
  endfunction

  // m: mode, sh: share, ea/eb: raw extension values
  task automatic run_cfg(input int m, input bit sh, input int ea, input int eb);
    int la, lb, n, steps;
    bit chained, err;
    la = 20 + ((ea > 80) ? 80 : ea);
    lb = 20 + ((eb > 80) ? 80 : eb);
    err = (ea > 80) || (eb > 80);
    chained = (m == 1) || (m == 2);
    steps = la + lb + 60;
    @(negedge clk);
    mode = 2'(m); share_in = sh; ext_a = 7'(ea); ext_b = 7'(eb);
    rst = 1'b1; ce = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 outputs cleared while in reset
    check("R1", "out_a in reset", int'(out_a), 0);
    check("R1", "out_b in reset", int'(out_b), 0);
    check("R1", "tap_out in reset", int'(tap_out), 0);
    rst = 1'b0;
    n = 0;
    for (int s = 0; s < steps; s++) begin
      bit c, da, db;
      if (s > 0) begin
        // R7 saturation flag
        check("R7", "config_error", int'(config_error), int'(err));
        if (chained) begin
          // R5 chained length and quiet A output
          check("R5", "out_b chained", int'(out_b), delayed(1'b0, n, la + lb));
          check("R5", "out_a chained", int'(out_a), 0);
          if (m == 2) check("R6", "tap_out", int'(tap_out), delayed(1'b0, n, la));
          else        check("R5", "tap_out chained", int'(tap_out), 0);
        end else begin
          // R2 / R10 separate half A
          check((m == 3) ? "R10" : "R2", "out_a", int'(out_a), delayed(1'b0, n, la));
          // R3 / R4 half B own or shared input
          check(sh ? "R4" : "R3", "out_b", int'(out_b), delayed(!sh, n, lb));
          check((m == 3) ? "R10" : "R2", "tap_out separate", int'(tap_out), 0);
        end
      end
      // R9 disturb configuration after release
      if (s == 5) begin
        mode = 2'(m ^ 1); share_in = !sh; ext_a = 7'(ea ^ 13); ext_b = 7'(eb ^ 37);
      end
      c = ($urandom_range(0, 7) != 0);  // R8 random idle edges
      da = 1'($urandom_range(0, 1));
      db = 1'($urandom_range(0, 1));
      ce = c; din_a = da; din_b = db;
      if (c) begin
        ha[n] = int'(da);
        hb[n] = int'(db);
        n++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run_cfg(0, 1'b0, 0, 0);
    run_cfg(0, 1'b0, 9, 56);
    run_cfg(0, 1'b0, 80, 80);
    run_cfg(0, 1'b1, 30, 5);
    run_cfg(1, 1'b0, 0, 0);
    run_cfg(1, 1'b0, 80, 80);
    run_cfg(1, 1'b0, 9, 56);
    run_cfg(2, 1'b0, 15, 40);
    run_cfg(2, 1'b1, 80, 0);
    run_cfg(3, 1'b0, 3, 7);
    run_cfg(3, 1'b1, 44, 12);
    run_cfg(0, 1'b0, 100, 127);
    run_cfg(1, 1'b0, 81, 2);
    run_cfg(2, 1'b0, 0, 81);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule